// File: doc/BRIEF.md
# Resynchronised Dual-Range Dual-Modulus Prescaler

This block divides a single fast clock by 16, 17, 32 or 33 for the feedback path of a frequency synthesizer loop. A ratio-select input picks the short range (16/17) or the long range (32/33). A modulus-control input picks the lower member of that pair when high and the higher member when low. The loop's swallow counter drives the modulus control and watches the output.

Both controls are sampled on the single input-clock edge at which the output rises. The values sampled there fix the length of the whole output period that begins at that edge, so every change takes effect on a period boundary and no period is ever cut short. The output comes straight from a flip-flop on the input clock, so its delay is one register stage whatever the counter state. The counter is a down-counter that is reloaded at each phase boundary. When the higher ratio is in force, the one extra input clock goes into the low phase. The high phase always keeps its nominal length.

Top module: `dm_prescaler`

## Requirements
- R1: A synchronous active-high reset drives `div_out` low on the clock edge that samples it. After reset is released, `div_out` stays low for exactly 8 input clocks, counted from the last reset edge, before its first rise. This holds whatever the control inputs are.
- R2: With ratio select = 0 and modulus control = 1 captured, the output period is 16 input clocks: 8 high, then 8 low.
- R3: With ratio select = 0 and modulus control = 0 captured, the output period is 17 input clocks: 8 high, then 9 low.
- R4: With ratio select = 1 and modulus control = 1 captured, the output period is 32 input clocks: 16 high, then 16 low.
- R5: With ratio select = 1 and modulus control = 0 captured, the output period is 33 input clocks: 16 high, then 17 low. No phase ever lasts longer than 17 clocks.
- R6: The modulus control is sampled only at the clock edge where `div_out` rises, and that sample alone sets the length of the period starting there. Its value on every other edge has no effect on the output.
- R7: The ratio select is likewise sampled only at the rising-output edge. Changing it at any other time alters neither the phase in progress nor the next low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 1 | 0 selects the 16/17 range, 1 selects the 32/33 range |
| mod_ctl | input | 1 | 1 selects the lower ratio of the range, 0 selects the higher |
| div_out | output | 1 | Registered divided clock |

## Verification
On every clock the bound checker measures how long each output phase lasts. It compares a finished high phase, and a finished low phase, against the lengths implied by the control values present at the edge where the output last rose. It also checks that no phase overruns the longest legal length and that reset forces the output low. The bench covers the behaviour a per-cycle property cannot show well. It holds each of the four ratios steady for many periods, toggles the controls on every cycle so that only the captured values can explain the measured lengths, and asserts reset in mid-period with the controls set to the long ratio to confirm the fixed 8-clock first low phase.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  // Control values held for one output period
  typedef struct packed {
    logic range_hi; // long range (32/33) in force
    logic extend;   // higher ratio in force: one extra input clock
  } dmp_sel_t;
endpackage

// File: rtl/dmp_ctrl_latch.sv
module dmp_ctrl_latch
  import dmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     capture,
  input  logic     ratio_sel,
  input  logic     mod_ctl,
  output dmp_sel_t sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q.range_hi <= 1'b0;
      sel_q.extend   <= 1'b0;
    end else if (capture) begin
      sel_q.range_hi <= ratio_sel;
      sel_q.extend   <= ~mod_ctl;
    end
  end
endmodule

// File: rtl/dmp_reload.sv
module dmp_reload
  import dmp_pkg::*;
#(
  parameter int LO_HALF      = 8,
  parameter int HI_HALF      = 16,
  parameter bit EXTRA_ON_LOW = 1'b1,
  parameter int CW           = 5
) (
  input  logic          out_q,
  input  logic          ratio_sel,
  input  logic          mod_ctl,
  input  dmp_sel_t      sel_q,
  output logic [CW-1:0] load_val
);
  localparam logic [CW-1:0] LO_BASE = CW'(LO_HALF - 1);
  localparam logic [CW-1:0] HI_BASE = CW'(HI_HALF - 1);

  logic ext_rise; // extra clock for the high phase about to start
  logic ext_fall; // extra clock for the low phase about to start

  generate
    if (EXTRA_ON_LOW) begin : g_ext_low
      assign ext_rise = 1'b0;
      assign ext_fall = sel_q.extend;
    end else begin : g_ext_high
      assign ext_rise = ~mod_ctl;
      assign ext_fall = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!out_q) begin
      // rising boundary: live inputs are the ones being captured now
      load_val = (ratio_sel ? HI_BASE : LO_BASE) + {{(CW-1){1'b0}}, ext_rise};
    end else begin
      // falling boundary: use the values held since the last rise
      load_val = (sel_q.range_hi ? HI_BASE : LO_BASE) + {{(CW-1){1'b0}}, ext_fall};
    end
  end
endmodule

// File: rtl/dmp_phase_counter.sv
module dmp_phase_counter #(
  parameter int CW      = 5,
  parameter int RST_VAL = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] load_val,
  output logic          tc
);
  logic [CW-1:0] cnt_q;

  assign tc = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= CW'(RST_VAL);
    else if (tc) cnt_q <= load_val;
    else         cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/dm_prescaler.sv
module dm_prescaler
  import dmp_pkg::*;
#(
  parameter int LO_HALF      = 8,
  parameter int HI_HALF      = 16,
  parameter bit EXTRA_ON_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ratio_sel,
  input  logic mod_ctl,
  output logic div_out
);
  localparam int CW = $clog2(HI_HALF + 2);

  logic          out_q;
  logic          tc;
  logic          capture;
  logic [CW-1:0] load_val;
  dmp_sel_t      sel_q;

  assign capture = tc & ~out_q;

  dmp_ctrl_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .ratio_sel (ratio_sel),
    .mod_ctl   (mod_ctl),
    .sel_q     (sel_q)
  );

  dmp_reload #(
    .LO_HALF      (LO_HALF),
    .HI_HALF      (HI_HALF),
    .EXTRA_ON_LOW (EXTRA_ON_LOW),
    .CW           (CW)
  ) u_reload (
    .out_q     (out_q),
    .ratio_sel (ratio_sel),
    .mod_ctl   (mod_ctl),
    .sel_q     (sel_q),
    .load_val  (load_val)
  );

  dmp_phase_counter #(
    .CW      (CW),
    .RST_VAL (LO_HALF - 1)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_val (load_val),
    .tc       (tc)
  );

  always_ff @(posedge clk) begin
    if (rst)     out_q <= 1'b0;
    else if (tc) out_q <= ~out_q;
  end

  assign div_out = out_q;
endmodule

// File: rtl/dmp_checker.sv
module dmp_checker #(
  parameter int LO_HALF      = 8,
  parameter int HI_HALF      = 16,
  parameter bit EXTRA_ON_LOW = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic ratio_sel,
  input logic mod_ctl,
  input logic div_out
);
  localparam int RW = $clog2(HI_HALF + 4);

  logic          prev_out, prev_ratio, prev_mod;
  logic [RW-1:0] run_q, exp_hi, exp_lo;
  logic [RW-1:0] half_now;
  logic          ext_now;

  assign half_now = prev_ratio ? RW'(HI_HALF) : RW'(LO_HALF);
  assign ext_now  = ~prev_mod;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_out   <= 1'b0;
      prev_ratio <= 1'b0;
      prev_mod   <= 1'b1;
      run_q      <= '0;
      exp_hi     <= RW'(LO_HALF);
      exp_lo     <= RW'(LO_HALF);
    end else begin
      prev_out   <= div_out;
      prev_ratio <= ratio_sel;
      prev_mod   <= mod_ctl;
      if (div_out != prev_out) run_q <= RW'(1);
      else                     run_q <= run_q + 1'b1;
      if (div_out && !prev_out) begin
        // the rise happened on the previous edge, with prev_* as inputs
        exp_hi <= half_now + ((!EXTRA_ON_LOW && ext_now) ? RW'(1) : RW'(0));
        exp_lo <= half_now + (( EXTRA_ON_LOW && ext_now) ? RW'(1) : RW'(0));
      end
    end
  end

  // R1: reset forces the output low on the following cycle
  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !div_out);

  // R6 (with R2..R5): a finished high phase matches the capture at its rise
  assert_high_phase_R6: assert property (@(posedge clk) disable iff (rst)
    (prev_out && !div_out) |-> (run_q == exp_hi));

  // R7 (with R1..R5): a finished low phase matches the capture at the previous rise
  assert_low_phase_R7: assert property (@(posedge clk) disable iff (rst)
    (!prev_out && div_out) |-> (run_q == exp_lo));

  // R5: no phase exceeds the longest legal length
  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(HI_HALF + 1));
endmodule

bind dm_prescaler dmp_checker #(
  .LO_HALF      (LO_HALF),
  .HI_HALF      (HI_HALF),
  .EXTRA_ON_LOW (EXTRA_ON_LOW)
) u_dmp_checker (
  .clk       (clk),
  .rst       (rst),
  .ratio_sel (ratio_sel),
  .mod_ctl   (mod_ctl),
  .div_out   (div_out)
);

// File: tb/test_dm_prescaler.sv
module test_dm_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int LO = 8;
  localparam int HI = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ratio_sel = 1'b0;
  logic mod_ctl = 1'b1;
  logic div_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // monitor state
  logic  prev = 1'b0;
  int    run = 0;
  int    exp_hi = LO;
  int    exp_lo = LO;
  string tag_cap = "R1";
  string phase_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_prescaler i_dm_prescaler (
    .clk       (clk),
    .rst       (rst),
    .ratio_sel (ratio_sel),
    .mod_ctl   (mod_ctl),
    .div_out   (div_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic string combo_tag(input logic r, input logic m);
    if (!r) return m ? "R2" : "R3";
    return m ? "R4" : "R5";
  endfunction

  // one input clock: sample at the falling edge, then drive new controls
  task automatic step(input logic r, input logic m);
    logic cur;
    @(negedge clk);
    cur = div_out;
    if (cur !== prev) begin
      if (prev) chk(run == exp_hi, {tag_cap, " high phase"}, run, exp_hi);
      else      chk(run == exp_lo, {tag_cap, " low phase"}, run, exp_lo);
      if (!prev) begin
        // controls driven last step were sampled at the rising edge
        exp_hi  = ratio_sel ? HI : LO;
        exp_lo  = exp_hi + (mod_ctl ? 0 : 1);
        tag_cap = (phase_tag == "") ? combo_tag(ratio_sel, mod_ctl) : phase_tag;
      end
      run = 1;
    end else begin
      run++;
    end
    prev = cur;
    ratio_sel = r;
    mod_ctl   = m;
  endtask

  task automatic do_reset(input logic r, input logic m);
    rst = 1'b1;
    ratio_sel = r;
    mod_ctl = m;
    @(negedge clk);
    @(negedge clk);
    chk(div_out == 1'b0, "R1 output low under reset", int'(div_out), 0);
    rst = 1'b0;
    prev = 1'b0;
    run = 1;
    exp_lo = LO;
    tag_cap = "R1";
  endtask

  initial begin
    do_reset(1'b0, 1'b1);
    // steady ratios: R2, R3, R4, R5
    phase_tag = "";
    repeat (6 * 34) step(1'b0, 1'b1);
    repeat (6 * 34) step(1'b0, 1'b0);
    repeat (6 * 34) step(1'b1, 1'b1);
    repeat (6 * 34) step(1'b1, 1'b0);
    // reset mid-period with long-ratio controls: first low still 8 (R1)
    repeat (5) step(1'b1, 1'b0);
    do_reset(1'b1, 1'b0);
    repeat (60) step(1'b1, 1'b0);
    // R6: modulus toggles every cycle, ratio fixed per block
    phase_tag = "R6";
    for (int b = 0; b < 6; b++) begin
      logic rfix;
      rfix = b[0];
      repeat (500) step(rfix, 1'($urandom));
    end
    // R7: both controls change every cycle
    phase_tag = "R7";
    repeat (3000) step(1'($urandom), 1'($urandom));
    phase_tag = "";
    repeat (40) step(1'b0, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule